// File: doc/BRIEF.md
# Core/System Clock Ratio Controller

The block turns one fast oscillator-rate clock into two clock-enable streams: one at the core-clock rate and one at the system-clock rate. Logic downstream keeps running on the fast clock and advances only on cycles where its enable is high, so no clock is ever gated or switched.

A six-bit divide register sets both rates. Bits [1:0] select the core ratio as a power of two. Bits [5:2] give the system ratio directly as an integer. Software may write the register at any time. The hardware corrects any write that would make the system divider smaller than the core divider, and readback shows the corrected value. A new setting waits in a pending copy. It becomes active only where both divider counters wrap together, so the change never produces a shortened enable period.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: Coming out of reset, readback is 0x10 (core select 0, system select 4). Both enables are high in the first cycle after reset is released.
- R2: The core select field, bits [1:0], sets the core ratio to 1, 2, 4 or 8 for the values 0, 1, 2 and 3.
- R3: The system select field, bits [5:2], sets the system ratio directly to its integer value, from 1 to 15.
- R4: A system select that is smaller than the core ratio is raised to the core ratio. A system select of 0 counts as smaller. The active system ratio is never below the active core ratio.
- R5: In the cycle after a write, readback returns the corrected fields in the same bit positions as the write.
- R6: Each enable is high for one cycle in every N cycles, where N is its active ratio. A ratio of 1 holds the enable high all the time.
- R7: A new setting becomes active only on a cycle where both counters wrap. While the change is taking place, every period between enable pulses equals either the old ratio or the new one.
- R8: When the system ratio is a multiple of the core ratio, every system enable pulse falls in a cycle where the core enable is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast oscillator-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the divide register |
| wr_data_i | input | 6 | Write data: system select in [5:2], core select in [1:0] |
| rd_data_o | output | 6 | Corrected divide register, same layout as the write data |
| core_en_o | output | 1 | Core-rate clock enable |
| sys_en_o | output | 1 | System-rate clock enable |

## Verification
Embedded properties check three things on every cycle:
- the system ratio never falls below the core ratio, and readback stays legal;
- each counter stays inside its ratio, a ratio of 1 keeps its enable high, and system pulses line up with core pulses for multiple ratios;
- the active ratios change only on a joint-wrap cycle.

Only the bench scenarios can show the rest:
- the actual pulse periods for each encoding;
- the clamp results for specific illegal writes;
- the reset state;
- that no period outside the old or new ratio appears when a change is made in mid-period.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int unsigned CORE_SEL_W  = 2;
  localparam int unsigned SYS_SEL_W   = 4;
  localparam int unsigned CORE_SEL_RST = 0;
  localparam int unsigned SYS_SEL_RST  = 4;
endpackage

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int unsigned RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ratio_i,
  output logic          en_o,
  output logic          wrap_o
);
  logic [RW-1:0] cnt_q;

  assign en_o   = (cnt_q == '0);
  assign wrap_o = (cnt_q >= ratio_i - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + RW'(1);
  end

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);
  p_unity_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_i == RW'(1)) |-> en_o);
endmodule

// File: rtl/clk_ratio_cfg.sv
module clk_ratio_cfg #(
  parameter int unsigned CORE_W   = 2,
  parameter int unsigned SYS_W    = 4,
  parameter int unsigned CORE_RST = 0,
  parameter int unsigned SYS_RST  = 4,
  localparam int unsigned DW      = CORE_W + SYS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             boundary_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [SYS_W-1:0] core_ratio_o,
  output logic [SYS_W-1:0] sys_ratio_o
);
  localparam logic [SYS_W-1:0] ONE = SYS_W'(1);

  logic [CORE_W-1:0] pend_core_q, act_core_q;
  logic [SYS_W-1:0]  pend_sys_q,  act_sys_q;
  logic [CORE_W-1:0] wr_core;
  logic [SYS_W-1:0]  wr_sys, wr_core_ratio, wr_sys_fix;

  assign wr_core       = wr_data_i[CORE_W-1:0];
  assign wr_sys        = wr_data_i[DW-1:CORE_W];
  assign wr_core_ratio = ONE << wr_core;
  // clamp: system ratio raised to at least the core ratio (0 is illegal)
  assign wr_sys_fix    = (wr_sys < wr_core_ratio) ? wr_core_ratio : wr_sys;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_core_q <= CORE_W'(CORE_RST);
      pend_sys_q  <= SYS_W'(SYS_RST);
      act_core_q  <= CORE_W'(CORE_RST);
      act_sys_q   <= SYS_W'(SYS_RST);
    end else begin
      if (wr_en_i) begin
        pend_core_q <= wr_core;
        pend_sys_q  <= wr_sys_fix;
      end
      if (boundary_i) begin
        act_core_q <= pend_core_q;
        act_sys_q  <= pend_sys_q;
      end
    end
  end

  assign rd_data_o    = {pend_sys_q, pend_core_q};
  assign core_ratio_o = ONE << act_core_q;
  assign sys_ratio_o  = act_sys_q;

  p_sys_ge_core_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_ratio_o >= core_ratio_o);
  p_rd_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_sys_q != '0) && (pend_sys_q >= (ONE << pend_core_q)));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(act_core_q) && $stable(act_sys_q));
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl
  import clk_ratio_pkg::*;
#(
  parameter int unsigned CORE_W   = CORE_SEL_W,
  parameter int unsigned SYS_W    = SYS_SEL_W,
  parameter int unsigned CORE_RST = CORE_SEL_RST,
  parameter int unsigned SYS_RST  = SYS_SEL_RST,
  localparam int unsigned DW      = CORE_W + SYS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          core_en_o,
  output logic          sys_en_o
);
  logic [SYS_W-1:0] ratio [2];
  logic [1:0]       en, wrap;
  logic             boundary;

  assign boundary = &wrap;

  clk_ratio_cfg #(
    .CORE_W(CORE_W), .SYS_W(SYS_W), .CORE_RST(CORE_RST), .SYS_RST(SYS_RST)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .boundary_i  (boundary),
    .rd_data_o,
    .core_ratio_o(ratio[0]),
    .sys_ratio_o (ratio[1])
  );

  // index 0: core divider, index 1: system divider
  for (genvar g = 0; g < 2; g++) begin : g_div
    clk_ratio_div #(.RW(SYS_W)) u_div (
      .clk_i, .rst_ni,
      .ratio_i(ratio[g]),
      .en_o   (en[g]),
      .wrap_o (wrap[g])
    );
  end

  assign core_en_o = en[0];
  assign sys_en_o  = en[1];

  p_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_en_o && ((ratio[1] & (ratio[0] - SYS_W'(1))) == '0)) |-> core_en_o);
endmodule

// File: tb/clk_ratio_ctrl_test.sv
module clk_ratio_ctrl_test;
  localparam time TCLK = 10ns;
  localparam int NV = 8;
  // {wr_data[21:16], exp_rd[15:10], core_period[9:5], sys_period[4:0]}
  localparam logic [21:0] VEC [NV] = '{
    {6'h10, 6'h10, 5'd1, 5'd4},
    {6'h19, 6'h19, 5'd2, 5'd6},
    {6'h0E, 6'h12, 5'd4, 5'd4},
    {6'h03, 6'h23, 5'd8, 5'd8},
    {6'h3F, 6'h3F, 5'd8, 5'd15},
    {6'h00, 6'h04, 5'd1, 5'd1},
    {6'h0D, 6'h0D, 5'd2, 5'd3},
    {6'h32, 6'h32, 5'd4, 5'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_data = '0, rd_data;
  logic core_en, sys_en;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  clk_ratio_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .core_en_o(core_en), .sys_en_o(sys_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [5:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // gaps between consecutive pulses over a window
  task automatic measure(output int cmin, output int cmax, output int smin,
                         output int smax, output int misalign);
    int lc = -1, ls = -1;
    cmin = 99; cmax = 0; smin = 99; smax = 0; misalign = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (core_en) begin
        if (lc >= 0) begin
          if (i - lc < cmin) cmin = i - lc;
          if (i - lc > cmax) cmax = i - lc;
        end
        lc = i;
      end
      if (sys_en) begin
        if (ls >= 0) begin
          if (i - ls < smin) smin = i - ls;
          if (i - ls > smax) smax = i - ls;
        end
        ls = i;
        if (!core_en) misalign++;
      end
    end
  endtask

  initial begin
    int cmin, cmax, smin, smax, mis;
    repeat (3) @(negedge clk);
    check("R1 reset readback", rd_data, 6'h10);
    rst_n = 1'b1;
    check("R1 core_en after reset", core_en, 1);
    check("R1 sys_en after reset", sys_en, 1);
    measure(cmin, cmax, smin, smax, mis);
    check("R6 reset core period", cmax, 1);
    check("R6 reset sys period min", smin, 4);
    check("R6 reset sys period max", smax, 4);

    for (int v = 0; v < NV; v++) begin
      write_reg(VEC[v][21:16]);
      check($sformatf("R4/R5 readback vec%0d", v), rd_data, VEC[v][15:10]);
      repeat (130) @(negedge clk);
      measure(cmin, cmax, smin, smax, mis);
      check($sformatf("R2/R6 core min vec%0d", v), cmin, VEC[v][9:5]);
      check($sformatf("R2/R6 core max vec%0d", v), cmax, VEC[v][9:5]);
      check($sformatf("R3/R4 sys min vec%0d", v), smin, VEC[v][4:0]);
      check($sformatf("R3/R4 sys max vec%0d", v), smax, VEC[v][4:0]);
      if (VEC[v][4:0] % VEC[v][9:5] == 0)
        check($sformatf("R8 alignment vec%0d", v), mis, 0);
    end

    // R7: mid-period change, every gap must be old or new ratio
    write_reg(6'h19);
    repeat (130) @(negedge clk);
    repeat (3) @(negedge clk);
    begin
      int lc = -1, ls = -1, bad_c = 0, bad_s = 0;
      wr_en = 1'b1; wr_data = 6'h32;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        wr_en = 1'b0;
        if (core_en) begin
          if (lc >= 0 && (i - lc) != 2 && (i - lc) != 4) bad_c++;
          lc = i;
        end
        if (sys_en) begin
          if (ls >= 0 && (i - ls) != 6 && (i - ls) != 12) bad_s++;
          ls = i;
        end
      end
      check("R7 core gaps outside old/new", bad_c, 0);
      check("R7 sys gaps outside old/new", bad_s, 0);
    end
    measure(cmin, cmax, smin, smax, mis);
    check("R7 new core period applied", cmax, 4);
    check("R7 new sys period applied", smin, 12);

    // R4: clamp at top core ratio with sys 7
    write_reg(6'h1F);
    check("R4 clamp sys 7 to 8", rd_data, 6'h23);
    done = 1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      done = 1;
    end
  end

  initial begin
    wait (done);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule